// File: doc/BRIEF.md
# Priority Threshold Receive Buffer

This block is the receive-side slot manager of a packet-switched endpoint. It tracks how many of its packet slots are in use and decides, for every arriving packet, whether to take it. The decision depends on the packet's link priority, on whether the packet is a response, and on the current occupancy. Every priority has a static occupancy limit. Ordinary request packets are additionally kept out of the topmost slots, which are held back so that responses can always land. A response always travels one priority level above the request it answers, so a response at the lowest priority is malformed and is turned away.

The block supports two flow-control styles, chosen by an input. In the receiver-driven style, each arrival gets exactly one accept or reject pulse on the following cycle, and the sender retries anything that was rejected. In the credit style, the block stays silent and the sender relies on the free-slot count, which the block shows at every cycle. Accepted packets are held as small descriptors (priority and response flag) in arrival order. The consumer removes them one at a time through a dequeue strobe. Payload storage, retransmission and error checking are outside this block.

Top module: `rxb_prio_queue`

## Requirements
- R1: After synchronous reset the block holds no packets: `credit` is 8, `head_valid` is 0, and `ack` and `nack` are 0.
- R2: A request packet (`arr_is_resp`=0) of priority p is accepted only while occupancy is below the smaller of the priority limit (6, 8, 8, 8 for p = 0, 1, 2, 3) and SLOTS−RESV (8−2 = 6). With the default settings, every request is refused once 6 slots are in use.
- R3: A response packet (`arr_is_resp`=1) with priority 1 to 3 may use the reserved slots. It is accepted while occupancy is below that priority's limit, which is 8 for priorities 1 to 3.
- R4: A response packet carrying priority 0 is always refused, and it leaves occupancy unchanged.
- R5: With `credit_mode`=0, every arrival is answered by exactly one of `ack` (accepted) or `nack` (refused). The answer is high for the single cycle that follows the arrival strobe, and both outputs are low when no arrival happened in the previous cycle.
- R6: With `credit_mode`=1, `ack` and `nack` stay low. The admission rules still apply, and a refused packet is dropped without changing occupancy.
- R7: `credit` equals 8 minus the occupancy. It reflects each accepted arrival or dequeue from the cycle after that event.
- R8: Packets leave in arrival order. `head_prio` and `head_is_resp` show the oldest held packet, and `head_valid` is 1 exactly when at least one packet is held.
- R9: A dequeue strobe while the block is empty has no effect: `credit` stays 8 and `head_valid` stays 0.
- R10: When an arrival and a dequeue occur in the same cycle, admission is judged on the occupancy before the dequeue. If the arrival is accepted, occupancy is unchanged. If it is refused, occupancy drops by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| credit_mode | input | 1 | 0 = answer every arrival with accept/reject, 1 = credit style (no answers) |
| arr_valid | input | 1 | Packet arrival strobe |
| arr_prio | input | 2 | Link priority of the arriving packet (0 lowest, 3 highest) |
| arr_is_resp | input | 1 | Arriving packet is a response |
| deq_req | input | 1 | Remove the oldest held packet |
| head_valid | output | 1 | At least one packet is held |
| head_prio | output | 2 | Priority of the oldest held packet |
| head_is_resp | output | 1 | Response flag of the oldest held packet |
| ack | output | 1 | Accept pulse, one cycle after arrival |
| nack | output | 1 | Reject pulse, one cycle after arrival |
| credit | output | 4 | Free slot count, 8 minus occupancy |

## Verification
A wrong occupancy count shows at the ports one cycle after the event that caused it. The `credit` value is off by the error, and the accept/reject answer to the next arrival near a limit flips. A count that drifts upward makes the reserved response slots vanish early, which shows as a `nack` to a response after only six requests. A corrupted descriptor pointer shows on `head_prio`/`head_is_resp` at the first dequeue after it.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int unsigned NUM_PRIO = 4;
    localparam int unsigned PRIO_W   = 2;

    typedef logic [PRIO_W-1:0] prio_t;

    // Descriptor kept for every admitted packet
    typedef struct packed {
        prio_t prio;
        logic  is_resp;
    } pkt_desc_t;

    typedef enum logic {
        FC_RECEIVER = 1'b0,
        FC_CREDIT   = 1'b1
    } fc_mode_e;

    // Never let a limit exceed the physical slot count
    function automatic int unsigned clamp_limit(int unsigned thr, int unsigned slots);
        return (thr > slots) ? slots : thr;
    endfunction

    // Occupancy limit for ordinary requests: priority limit, minus the reserved top
    function automatic int unsigned request_limit(int unsigned thr, int unsigned slots,
                                                  int unsigned resv);
        int unsigned lim;
        int unsigned open_slots;
        lim        = clamp_limit(thr, slots);
        open_slots = (resv >= slots) ? 0 : slots - resv;
        if (open_slots < lim) begin
            lim = open_slots;
        end
        return lim;
    endfunction

    // Occupancy limit for responses; a response never uses the lowest priority
    function automatic int unsigned response_limit(int unsigned prio, int unsigned thr,
                                                   int unsigned slots);
        return (prio == 0) ? 0 : clamp_limit(thr, slots);
    endfunction

endpackage

// File: rtl/rxb_admit.sv
module rxb_admit
    import rxb_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned RESV  = 2,
    parameter int unsigned PRIO_THR [NUM_PRIO] = '{6, 8, 8, 8},
    localparam int unsigned CW = $clog2(SLOTS + 1)
) (
    input  logic [CW-1:0] occ,
    input  pkt_desc_t     desc,
    output logic          pass
);

    logic [NUM_PRIO-1:0] req_ok;
    logic [NUM_PRIO-1:0] rsp_ok;

    // One comparator pair per priority level
    for (genvar p = 0; p < NUM_PRIO; p++) begin : g_prio
        localparam int unsigned REQ_LIM = request_limit(PRIO_THR[p], SLOTS, RESV);
        localparam int unsigned RSP_LIM = response_limit(p, PRIO_THR[p], SLOTS);
        localparam logic [CW-1:0] REQ_LIM_C = CW'(REQ_LIM);
        localparam logic [CW-1:0] RSP_LIM_C = CW'(RSP_LIM);

        assign req_ok[p] = (occ < REQ_LIM_C);
        assign rsp_ok[p] = (occ < RSP_LIM_C);
    end

    always_comb begin
        if (desc.is_resp) begin
            pass = rsp_ok[desc.prio];
        end else begin
            pass = req_ok[desc.prio];
        end
    end

endmodule

// File: rtl/rxb_desc_fifo.sv
module rxb_desc_fifo
    import rxb_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned CW    = $clog2(SLOTS + 1),
    localparam int unsigned PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  pkt_desc_t     push_desc,
    input  logic          pop,
    output pkt_desc_t     head_desc,
    output logic [CW-1:0] occ
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(SLOTS - 1);

    pkt_desc_t        mem [SLOTS];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             pop_ok;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] ptr);
        return (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
    endfunction

    // A pop on an empty store is dropped here
    assign pop_ok = pop && (occ != '0);

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_desc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push, pop_ok})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    assign head_desc = mem[rd_ptr];

endmodule

// File: rtl/rxb_flow_reply.sv
module rxb_flow_reply
    import rxb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  fc_mode_e mode,
    input  logic     arr_valid,
    input  logic     pass,
    output logic     ack,
    output logic     nack
);

    logic answer;

    assign answer = arr_valid && (mode == FC_RECEIVER);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack  <= 1'b0;
            nack <= 1'b0;
        end else begin
            ack  <= answer && pass;
            nack <= answer && !pass;
        end
    end

endmodule

// File: rtl/rxb_prio_queue.sv
module rxb_prio_queue
    import rxb_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned RESV  = 2,
    parameter int unsigned PRIO_THR [NUM_PRIO] = '{6, 8, 8, 8},
    localparam int unsigned CW = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              credit_mode,
    input  logic              arr_valid,
    input  logic [PRIO_W-1:0] arr_prio,
    input  logic              arr_is_resp,
    input  logic              deq_req,
    output logic              head_valid,
    output logic [PRIO_W-1:0] head_prio,
    output logic              head_is_resp,
    output logic              ack,
    output logic              nack,
    output logic [CW-1:0]     credit
);

    localparam logic [CW-1:0] SLOTS_C = CW'(SLOTS);

    pkt_desc_t     arr_desc;
    pkt_desc_t     head_desc;
    logic          pass;
    logic [CW-1:0] occ;
    fc_mode_e      mode;

    assign arr_desc.prio    = arr_prio;
    assign arr_desc.is_resp = arr_is_resp;
    assign mode             = fc_mode_e'(credit_mode);

    rxb_admit #(
        .SLOTS    (SLOTS),
        .RESV     (RESV),
        .PRIO_THR (PRIO_THR)
    ) u_admit (
        .occ  (occ),
        .desc (arr_desc),
        .pass (pass)
    );

    rxb_desc_fifo #(
        .SLOTS (SLOTS)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (arr_valid && pass),
        .push_desc (arr_desc),
        .pop       (deq_req),
        .head_desc (head_desc),
        .occ       (occ)
    );

    rxb_flow_reply u_reply (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .arr_valid (arr_valid),
        .pass      (pass),
        .ack       (ack),
        .nack      (nack)
    );

    assign credit       = SLOTS_C - occ;
    assign head_valid   = (occ != '0);
    assign head_prio    = head_desc.prio;
    assign head_is_resp = head_desc.is_resp;

endmodule

// File: rtl/rxb_prio_queue_chk.sv
module rxb_prio_queue_chk
    import rxb_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned RESV  = 2,
    localparam int unsigned CW = $clog2(SLOTS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              credit_mode,
    input logic              arr_valid,
    input logic [PRIO_W-1:0] arr_prio,
    input logic              arr_is_resp,
    input logic              deq_req,
    input logic              head_valid,
    input logic [PRIO_W-1:0] head_prio,
    input logic              head_is_resp,
    input logic              ack,
    input logic              nack,
    input logic [CW-1:0]     credit
);

    localparam logic [CW-1:0] SLOTS_C = CW'(SLOTS);
    localparam logic [CW-1:0] RESV_C  = CW'(RESV);

    // R2
    request_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_valid && !arr_is_resp && !credit_mode && credit <= RESV_C) |=> nack);

    // R4
    low_resp_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_valid && arr_is_resp && arr_prio == '0 && !credit_mode) |=> nack);

    // R5
    one_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_valid && !credit_mode) |=> (ack != nack));

    // R5
    no_spurious_answer_chk: assert property (@(posedge clk) disable iff (rst)
        !arr_valid |=> (!ack && !nack));

    // R6
    credit_silent_chk: assert property (@(posedge clk) disable iff (rst)
        credit_mode |=> (!ack && !nack));

    // R7
    credit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        credit <= SLOTS_C);

    // R7
    accept_takes_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !$past(deq_req)) |-> (credit + 1'b1 == $past(credit)));

    // R9
    empty_deq_chk: assert property (@(posedge clk) disable iff (rst)
        (!arr_valid && deq_req && credit == SLOTS_C) |=> (credit == SLOTS_C && !head_valid));

endmodule

bind rxb_prio_queue rxb_prio_queue_chk #(.SLOTS(SLOTS), .RESV(RESV)) u_chk (.*);

// File: tb/rxb_prio_queue_bench.sv
module rxb_prio_queue_bench;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       credit_mode = 1'b0;
    logic       arr_valid = 1'b0;
    logic [1:0] arr_prio = '0;
    logic       arr_is_resp = 1'b0;
    logic       deq_req = 1'b0;
    logic       head_valid;
    logic [1:0] head_prio;
    logic       head_is_resp;
    logic       ack;
    logic       nack;
    logic [3:0] credit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(PERIOD / 2) clk = ~clk;

    rxb_prio_queue u_rxb_prio_queue (
        .clk          (clk),
        .rst          (rst),
        .credit_mode  (credit_mode),
        .arr_valid    (arr_valid),
        .arr_prio     (arr_prio),
        .arr_is_resp  (arr_is_resp),
        .deq_req      (deq_req),
        .head_valid   (head_valid),
        .head_prio    (head_prio),
        .head_is_resp (head_is_resp),
        .ack          (ack),
        .nack         (nack),
        .credit       (credit)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic do_reset(bit mode);
        @(negedge clk);
        rst         = 1'b1;
        credit_mode = mode;
        arr_valid   = 1'b0;
        deq_req     = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive one cycle of stimulus, sample just after the edge that registers it
    task automatic send(bit valid, int prio, bit resp, bit deq);
        @(negedge clk);
        arr_valid   = valid;
        arr_prio    = 2'(prio);
        arr_is_resp = resp;
        deq_req     = deq;
        @(posedge clk);
        #1;
        arr_valid = 1'b0;
        deq_req   = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        #1;
        check("R1 credit", int'(credit), 8);
        check("R1 head_valid", int'(head_valid), 0);
        check("R1 ack/nack", int'({ack, nack}), 0);
    endtask

    task automatic t_request_fill();
        do_reset(1'b0);
        for (int i = 0; i < 6; i++) begin
            send(1, 0, 0, 0);
            check("R5 ack on request", int'({ack, nack}), 2);
            check("R7 credit after accept", int'(credit), 7 - i);
        end
        send(0, 0, 0, 0);
        check("R5 pulse lasts one cycle", int'({ack, nack}), 0);
        send(1, 3, 0, 0);
        check("R2 high request blocked by reserve", int'({ack, nack}), 1);
        check("R2 credit unchanged", int'(credit), 2);
        send(1, 1, 0, 0);
        check("R2 prio1 request blocked", int'(nack), 1);
    endtask

    task automatic t_response_reserve();
        send(1, 1, 1, 0);
        check("R3 response uses reserve", int'(ack), 1);
        check("R3 credit", int'(credit), 1);
        send(1, 2, 1, 0);
        check("R3 second reserved slot", int'(ack), 1);
        check("R3 credit full", int'(credit), 0);
        send(1, 3, 1, 0);
        check("R3 response refused when full", int'(nack), 1);
        check("R3 credit stays 0", int'(credit), 0);
    endtask

    task automatic t_low_response();
        do_reset(1'b0);
        send(1, 0, 1, 0);
        check("R4 prio0 response refused", int'({ack, nack}), 1);
        check("R4 credit unchanged", int'(credit), 8);
        check("R4 nothing held", int'(head_valid), 0);
    endtask

    task automatic t_order();
        do_reset(1'b0);
        send(1, 2, 0, 0);
        send(1, 0, 0, 0);
        send(1, 3, 1, 0);
        check("R8 head_valid", int'(head_valid), 1);
        check("R8 first head", int'({head_prio, head_is_resp}), (2 << 1) | 0);
        send(0, 0, 0, 1);
        check("R8 second head", int'({head_prio, head_is_resp}), (0 << 1) | 0);
        send(0, 0, 0, 1);
        check("R8 third head", int'({head_prio, head_is_resp}), (3 << 1) | 1);
        send(0, 0, 0, 1);
        check("R8 drained", int'(head_valid), 0);
        check("R7 credit back to 8", int'(credit), 8);
    endtask

    task automatic t_empty_dequeue();
        do_reset(1'b0);
        send(0, 0, 0, 1);
        check("R9 credit after empty dequeue", int'(credit), 8);
        check("R9 head_valid", int'(head_valid), 0);
        send(1, 1, 0, 0);
        check("R9 later arrival counts once", int'(credit), 7);
    endtask

    task automatic t_same_cycle();
        do_reset(1'b0);
        for (int i = 0; i < 6; i++) begin
            send(1, 0, 0, 0);
        end
        send(1, 0, 0, 1);
        check("R10 judged before dequeue", int'(nack), 1);
        check("R10 refused arrival plus dequeue", int'(credit), 3);
        send(1, 0, 0, 1);
        check("R10 accepted at occupancy 5", int'(ack), 1);
        check("R10 occupancy unchanged", int'(credit), 3);
    endtask

    task automatic t_credit_mode();
        do_reset(1'b1);
        for (int i = 0; i < 6; i++) begin
            send(1, 0, 0, 0);
            check("R6 silent on accept", int'({ack, nack}), 0);
        end
        check("R6 credit after six", int'(credit), 2);
        send(1, 0, 0, 0);
        check("R6 silent on refusal", int'({ack, nack}), 0);
        check("R6 refused arrival dropped", int'(credit), 2);
        send(1, 1, 1, 0);
        check("R6 response still admitted", int'(credit), 1);
    endtask

    initial begin
        t_reset();
        t_request_fill();
        t_response_reserve();
        t_low_response();
        t_order();
        t_empty_dequeue();
        t_same_cycle();
        t_credit_mode();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule